// File: doc/BRIEF.md
# Quad SPI Command-Sequenced Master

This block is a serial flash-style master that carries out one transaction per programmed command. A transaction is made of up to four phases, always in the same order: an 8-bit instruction, an address of 8, 16, 24 or 32 bits, a run of dummy clocks and a data phase of one or more bytes. Each phase can be skipped or driven on one line or on four lines, chosen independently of the other phases. A one-line instruction followed by four-line data is therefore a legal combination.

Software programs the block through a small write port with five register selects: configuration, length, address, transmit data and flag clear. There is no start bit. The transaction launches itself on the last write it depends on. That write is the address when an address phase is configured, and otherwise the configuration word. In read mode, received bytes enter an eight-entry FIFO, software pops them one at a time, and a level flag is raised at a programmed threshold. In write mode, software pushes bytes into the same FIFO ahead of time, and the serial clock pauses whenever the FIFO runs dry. A busy flag spans the whole transaction, and a sticky completion flag marks its end.

Top module: `qspi_master`

## Requirements
- R1: Each phase has a 2-bit line mode, where 0 skips the phase, 1 uses one line and 2 uses four lines. On one line the master drives io[0] and samples io[1]. On four lines it uses io[3:0]. Modes sit in the configuration word at imode [1:0], admode [3:2] and dmode [5:4].
- R2: Bits go out most significant first. On four lines each byte is sent upper nibble first, with io[3] carrying the highest bit of the nibble. Outputs change only while sclk is low, and inputs are sampled on the rising sclk edge (mode 0).
- R3: The address size field at config [7:6] selects (n+1)*8 address bits. Only the lowest that many bits of the address register are sent, most significant first.
- R4: The dummy count at config [12:8] gives the number of sclk cycles between address and data. All lines are released during those cycles.
- R5: The length register (select 1) holds the byte count minus one.
- R6: With admode nonzero, a write to the address register (select 2) launches the transaction and a configuration write (select 0) does not. With admode zero, the configuration write launches it.
- R7: busy rises in the cycle after the launching write. cs_n is low exactly while busy is high, and sclk is low whenever cs_n is high. cs_n rises two clocks after the last sclk high cycle, which is one clock after the last falling edge.
- R8: Writes to the configuration, length or address registers while busy is high are ignored and launch nothing.
- R9: In read mode (config bit 13 set), received bytes enter the FIFO and are popped with rx_pop, oldest first. fifo_thr is high when the level is nonzero and at least the threshold held at config [27:24].
- R10: tcf is set when a transaction ends. Writing 1 to bit 0 of the flag clear register (select 4) clears it.
- R11: In write mode, data bytes come from the FIFO, which software fills through select 3. If the FIFO is empty at a byte boundary, sclk is held low with cs_n asserted until a byte arrives.
- R12: The instruction byte is taken from config [23:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 config, 1 length, 2 address, 3 tx data, 4 flag clear |
| reg_wdata | input | 32 | Register write data |
| rx_pop | input | 1 | Pop one byte from the FIFO |
| rx_data | output | 8 | Byte at the FIFO head |
| rx_level | output | 4 | FIFO fill level |
| busy | output | 1 | Transaction in progress |
| tcf | output | 1 | Sticky transfer-complete flag |
| fifo_thr | output | 1 | FIFO level at or above threshold |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
busy is sampled at the falling clock edge right after the launching write, where it must already be high. For a configuration write that waits for an address, busy is watched over ten more cycles to confirm it stays low. The serial waveform is recorded on every rising sclk edge and compared edge by edge against a sequence computed from the configuration, so counting edges replaces counting clock cycles. The release of cs_n is timed against the last clock cycle in which sclk was high, and it must come exactly two clocks later. FIFO contents, fifo_thr and tcf are read only after busy has fallen, and each pop is checked at the falling edge before the pop strobe takes effect.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    localparam int ADDR_BITS = 32;

    localparam logic [2:0] SEL_CFG  = 3'd0;
    localparam logic [2:0] SEL_LEN  = 3'd1;
    localparam logic [2:0] SEL_ADDR = 3'd2;
    localparam logic [2:0] SEL_TXD  = 3'd3;
    localparam logic [2:0] SEL_FCLR = 3'd4;

    typedef struct packed {
        logic [3:0] thr;
        logic [7:0] instr;
        logic       rd;
        logic [4:0] dummy;
        logic [1:0] asize;
        logic [1:0] dmode;
        logic [1:0] amode;
        logic [1:0] imode;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LAUNCH, ST_INSTR, ST_ADDR, ST_DUMMY, ST_DATA, ST_END
    } st_e;

    function automatic cfg_t decode_cfg(logic [31:0] w);
        cfg_t c;
        c.imode = w[1:0];
        c.amode = w[3:2];
        c.dmode = w[5:4];
        c.asize = w[7:6];
        c.dummy = w[12:8];
        c.rd    = w[13];
        c.instr = w[23:16];
        c.thr   = w[27:24];
        return c;
    endfunction

    // next enabled phase strictly after s
    function automatic st_e next_phase(st_e s, cfg_t c);
        if (s < ST_INSTR && c.imode != 2'd0)      return ST_INSTR;
        else if (s < ST_ADDR && c.amode != 2'd0)  return ST_ADDR;
        else if (s < ST_DUMMY && c.dummy != 5'd0) return ST_DUMMY;
        else if (s < ST_DATA && c.dmode != 2'd0)  return ST_DATA;
        else                                      return ST_END;
    endfunction

endpackage

// File: rtl/qspi_fifo.sv
module qspi_fifo #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic          pop,
    output logic [7:0]    dout,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop)
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)
                level <= level + 1'b1;
            else if (do_pop && !do_push)
                level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
    import qspi_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 launch,
    input  cfg_t                 cfg,
    input  logic [LEN_W-1:0]     len,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic                 tx_empty,
    input  logic                 rx_full,
    input  logic [7:0]           tx_byte,
    input  logic [3:0]           io_in,
    output logic                 pop_tx,
    output logic                 push_rx,
    output logic [7:0]           rx_byte,
    output logic                 done,
    output logic                 busy,
    output logic                 sclk,
    output logic                 cs_n,
    output logic [3:0]           io_out,
    output logic [3:0]           io_oe
);
    st_e              st, nxt;
    logic             half, need_ld;
    logic [5:0]       cyc, ld_cyc, abits;
    logic [LEN_W-1:0] bleft;
    logic [31:0]      shreg, ld_sh;
    logic [7:0]       rx_sh;
    logic [1:0]       cur_mode;
    logic             qd, load_slot, load_ok;
    logic [5:0]       byte_cyc;

    assign nxt = next_phase(st, cfg);
    assign abits = {1'b0, cfg.asize, 3'b000} + 6'd8;

    always_comb begin
        ld_sh  = '0;
        ld_cyc = '0;
        case (nxt)
            ST_INSTR: begin
                ld_sh  = {cfg.instr, 24'b0};
                ld_cyc = cfg.imode[1] ? 6'd2 : 6'd8;
            end
            ST_ADDR: begin
                ld_sh  = addr << (6'd32 - abits);
                ld_cyc = cfg.amode[1] ? (abits >> 2) : abits;
            end
            ST_DUMMY: ld_cyc = {1'b0, cfg.dummy};
            ST_DATA:  ld_cyc = cfg.dmode[1] ? 6'd2 : 6'd8;
            default:  ;
        endcase
    end

    always_comb begin
        case (st)
            ST_INSTR: cur_mode = cfg.imode;
            ST_ADDR:  cur_mode = cfg.amode;
            ST_DATA:  cur_mode = cfg.dmode;
            default:  cur_mode = 2'd0;
        endcase
    end

    assign qd        = cur_mode[1];
    assign byte_cyc  = cfg.dmode[1] ? 6'd2 : 6'd8;
    assign load_slot = (st == ST_DATA) && need_ld && !half;
    assign load_ok   = cfg.rd ? !rx_full : !tx_empty;
    assign pop_tx    = load_slot && load_ok && !cfg.rd;
    assign push_rx   = (st == ST_DATA) && half && (cyc == 6'd1) && cfg.rd;
    assign rx_byte   = rx_sh;
    assign done      = (st == ST_END);
    assign busy      = (st != ST_IDLE);
    assign cs_n      = (st == ST_IDLE);
    assign io_out    = qd ? shreg[31:28] : {3'b000, shreg[31]};

    always_comb begin
        if (st == ST_INSTR || st == ST_ADDR || (st == ST_DATA && !cfg.rd))
            io_oe = qd ? 4'hF : 4'h1;
        else
            io_oe = 4'h0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            sclk    <= 1'b0;
            half    <= 1'b0;
            cyc     <= '0;
            bleft   <= '0;
            shreg   <= '0;
            rx_sh   <= '0;
            need_ld <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (launch) st <= ST_LAUNCH;
                ST_LAUNCH: begin
                    st      <= nxt;
                    shreg   <= ld_sh;
                    cyc     <= ld_cyc;
                    need_ld <= (nxt == ST_DATA);
                    bleft   <= len;
                    half    <= 1'b0;
                end
                ST_END: st <= ST_IDLE;
                default: begin
                    if (load_slot) begin
                        if (load_ok) begin
                            need_ld <= 1'b0;
                            if (!cfg.rd) shreg <= {tx_byte, 24'b0};
                        end
                    end else if (!half) begin
                        sclk <= 1'b1;
                        half <= 1'b1;
                        if (st == ST_DATA && cfg.rd)
                            rx_sh <= qd ? {rx_sh[3:0], io_in} : {rx_sh[6:0], io_in[1]};
                    end else begin
                        sclk  <= 1'b0;
                        half  <= 1'b0;
                        shreg <= qd ? (shreg << 4) : (shreg << 1);
                        if (cyc == 6'd1) begin
                            if (st == ST_DATA && bleft != '0) begin
                                bleft   <= bleft - 1'b1;
                                cyc     <= byte_cyc;
                                need_ld <= 1'b1;
                            end else begin
                                st      <= nxt;
                                shreg   <= ld_sh;
                                cyc     <= ld_cyc;
                                need_ld <= (nxt == ST_DATA);
                                bleft   <= len;
                            end
                        end else begin
                            cyc <= cyc - 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/qspi_master.sv
module qspi_master
    import qspi_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int LEN_W = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [2:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    input  logic             rx_pop,
    output logic [7:0]       rx_data,
    output logic [LVL_W-1:0] rx_level,
    output logic             busy,
    output logic             tcf,
    output logic             fifo_thr,
    output logic             sclk,
    output logic             cs_n,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    input  logic [3:0]       io_in
);
    cfg_t                 cfg_r;
    logic [LEN_W-1:0]     len_r;
    logic [ADDR_BITS-1:0] addr_r;
    logic                 wr_ok, launch, done;
    logic                 pop_tx, push_rx, sw_push;
    logic [7:0]           rx_byte, fifo_din;
    logic                 f_full, f_empty;
    cfg_t                 cfg_new;

    assign cfg_new = decode_cfg(reg_wdata);
    assign wr_ok   = reg_we && !busy;
    assign launch  = wr_ok && (((reg_sel == SEL_CFG) && (cfg_new.amode == 2'd0)) ||
                               ((reg_sel == SEL_ADDR) && (cfg_r.amode != 2'd0)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_r  <= '0;
            len_r  <= '0;
            addr_r <= '0;
            tcf    <= 1'b0;
        end else begin
            if (wr_ok && reg_sel == SEL_CFG)  cfg_r  <= cfg_new;
            if (wr_ok && reg_sel == SEL_LEN)  len_r  <= reg_wdata[LEN_W-1:0];
            if (wr_ok && reg_sel == SEL_ADDR) addr_r <= reg_wdata;
            if (done)
                tcf <= 1'b1;
            else if (reg_we && reg_sel == SEL_FCLR && reg_wdata[0])
                tcf <= 1'b0;
        end
    end

    assign sw_push  = reg_we && (reg_sel == SEL_TXD) && !push_rx;
    assign fifo_din = push_rx ? rx_byte : reg_wdata[7:0];
    assign fifo_thr = (rx_level != '0) && (int'(rx_level) >= int'(cfg_r.thr));

    qspi_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst(rst),
        .push(push_rx || sw_push), .din(fifo_din),
        .pop(pop_tx || rx_pop), .dout(rx_data),
        .level(rx_level), .full(f_full), .empty(f_empty)
    );

    qspi_seq #(.LEN_W(LEN_W)) seq_i (
        .clk(clk), .rst(rst), .launch(launch), .cfg(cfg_r),
        .len(len_r), .addr(addr_r),
        .tx_empty(f_empty), .rx_full(f_full), .tx_byte(rx_data),
        .io_in(io_in), .pop_tx(pop_tx), .push_rx(push_rx), .rx_byte(rx_byte),
        .done(done), .busy(busy), .sclk(sclk), .cs_n(cs_n),
        .io_out(io_out), .io_oe(io_oe)
    );
endmodule

// File: rtl/qspi_chk.sv
module qspi_chk
    import qspi_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sclk,
    input logic       busy,
    input logic       tcf,
    input logic [3:0] io_oe,
    input logic       launch,
    input logic       pop_tx,
    input logic       f_empty,
    input cfg_t       cfg_r
);
    assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    assert_lines_released_R7: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (io_oe == 4'h0));

    assert_launch_busy_R6: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy);

    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_r));

    assert_end_flag_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> tcf);

    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (rst)
        pop_tx |-> !f_empty);
endmodule

bind qspi_master qspi_chk chk_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .busy(busy), .tcf(tcf),
    .io_oe(io_oe), .launch(launch), .pop_tx(pop_tx), .f_empty(f_empty),
    .cfg_r(cfg_r)
);

// File: tb/qspi_master_tb.sv
module qspi_master_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_data;
    logic [3:0]  rx_level;
    logic        busy, tcf, fifo_thr, sclk, cs_n;
    logic [3:0]  io_out, io_oe;
    logic [3:0]  io_in = 4'h0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    qspi_master dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_level(rx_level), .busy(busy), .tcf(tcf), .fifo_thr(fifo_thr),
        .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    // serial line recorder and responder
    int nedge = 0;
    logic [3:0] rec_o [256];
    logic [3:0] rec_e [256];
    int nexp = 0;
    logic [3:0] exp_o [256];
    logic [3:0] exp_e [256];

    function automatic logic [3:0] pat(int k);
        return 4'((k * 5 + 3) & 15);
    endfunction

    always @(posedge sclk) begin
        if (!cs_n && nedge < 256) begin
            rec_o[nedge] = io_out;
            rec_e[nedge] = io_oe;
            nedge = nedge + 1;
        end
    end

    always @(negedge sclk) io_in = pat(nedge);

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [31:0] mkcfg(int im, int am, int dm, int asz,
                                          int dum, int rd, int ins, int thr);
        return 32'((im & 3) | ((am & 3) << 2) | ((dm & 3) << 4) | ((asz & 3) << 6) |
                   ((dum & 31) << 8) | ((rd & 1) << 13) | ((ins & 255) << 16) |
                   ((thr & 15) << 24));
    endfunction

    task automatic arm();
        nedge = 0;
        nexp = 0;
        io_in = pat(0);
    endtask

    task automatic exp_bits(logic [31:0] v, int nbits, int mode, bit drv);
        if (mode == 1) begin
            for (int i = nbits - 1; i >= 0; i--) begin
                exp_o[nexp] = {3'b000, v[i]};
                exp_e[nexp] = drv ? 4'h1 : 4'h0;
                nexp++;
            end
        end else begin
            for (int i = nbits - 4; i >= 0; i -= 4) begin
                exp_o[nexp] = v[i +: 4];
                exp_e[nexp] = drv ? 4'hF : 4'h0;
                nexp++;
            end
        end
    endtask

    task automatic exp_dummy(int n);
        for (int i = 0; i < n; i++) begin
            exp_o[nexp] = 4'h0; exp_e[nexp] = 4'h0; nexp++;
        end
    endtask

    task automatic cmp_edges(string req);
        int bad = 0;
        check(nedge == nexp, {req, " edge count"}, nedge, nexp);
        for (int i = 0; i < nexp && i < nedge; i++)
            if (rec_e[i] != exp_e[i] || ((rec_o[i] & rec_e[i]) != (exp_o[i] & exp_e[i])))
                bad++;
        check(bad == 0, {req, " edge contents"}, bad, 0);
    endtask

    task automatic wait_idle(output int last_hi_gap);
        int cyc = 0;
        int last_hi = 0;
        last_hi_gap = -1;
        while (busy && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (sclk) last_hi = cyc;
            if (!busy) last_hi_gap = cyc - last_hi;
        end
    endtask

    task automatic pop_check(logic [7:0] e, string req);
        @(negedge clk);
        check(rx_data == e, req, rx_data, e);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic t_reset();
        check(cs_n == 1'b1 && sclk == 1'b0 && io_oe == 4'h0, "R7 reset lines", {cs_n, sclk, io_oe}, 6'b100000);
        check(busy == 1'b0 && tcf == 1'b0 && rx_level == 4'd0, "R10 reset flags", {busy, tcf, rx_level}, 0);
    endtask

    // quad read: 1-line instruction, 4-line 24-bit address, 6 dummy, 4-line data
    task automatic t_quad_read();
        int gap;
        logic [7:0] b;
        int k0;
        arm();
        wr(3'd1, 32'd3);
        wr(3'd0, mkcfg(1, 2, 2, 2, 6, 1, 8'hEB, 3));
        repeat (10) @(negedge clk);
        check(busy == 1'b0, "R6 config alone waits for address", busy, 0);
        wr(3'd2, 32'hAB123456);
        check(busy == 1'b1, "R7 busy after address write", busy, 1);
        exp_bits(32'hEB, 8, 1, 1);
        exp_bits(32'h123456, 24, 2, 1);
        exp_dummy(6);
        k0 = nexp;
        exp_dummy(8);
        wait_idle(gap);
        check(gap == 2, "R7 cs release timing", gap, 2);
        cmp_edges("R1 R3 R4 R12 quad read");
        check(tcf == 1'b1, "R10 tcf set", tcf, 1);
        check(rx_level == 4'd4, "R5 byte count", rx_level, 4);
        check(fifo_thr == 1'b1, "R9 threshold reached", fifo_thr, 1);
        for (int j = 0; j < 4; j++) begin
            b = {pat(k0 + 2 * j), pat(k0 + 2 * j + 1)};
            pop_check(b, "R9 R2 quad read byte");
        end
        check(fifo_thr == 1'b0, "R9 threshold cleared when empty", fifo_thr, 0);
    endtask

    task automatic t_flag_clear();
        wr(3'd4, 32'h1);
        check(tcf == 1'b0, "R10 flag clear", tcf, 0);
    endtask

    // single write with empty-FIFO stall, plus ignored writes while busy
    task automatic t_write_stall();
        int gap;
        arm();
        wr(3'd1, 32'd1);
        wr(3'd3, 32'hA5);
        wr(3'd0, mkcfg(1, 0, 1, 0, 0, 0, 8'h02, 1));
        check(busy == 1'b1, "R6 config launches when no address", busy, 1);
        wr(3'd1, 32'd5);
        wr(3'd0, mkcfg(2, 0, 2, 0, 0, 0, 8'h77, 1));
        repeat (200) @(negedge clk);
        check(busy == 1'b1 && cs_n == 1'b0, "R11 stall holds chip select", busy, 1);
        check(nedge == 16, "R11 clock paused at byte boundary", nedge, 16);
        wr(3'd3, 32'h3C);
        exp_bits(32'h02, 8, 1, 1);
        exp_bits(32'hA5, 8, 1, 1);
        exp_bits(32'h3C, 8, 1, 1);
        wait_idle(gap);
        cmp_edges("R8 R11 single write");
        repeat (20) @(negedge clk);
        check(busy == 1'b0, "R8 busy-time config did not launch", busy, 0);
    endtask

    // single read, length kept from before (R8: busy-time length write dropped)
    task automatic t_single_read();
        int gap;
        int k0;
        logic [7:0] b;
        arm();
        wr(3'd0, mkcfg(1, 0, 1, 0, 0, 1, 8'h9F, 2));
        exp_bits(32'h9F, 8, 1, 1);
        k0 = nexp;
        exp_dummy(16);
        wait_idle(gap);
        cmp_edges("R8 R1 single read");
        check(rx_level == 4'd2, "R8 length unchanged by busy write", rx_level, 2);
        for (int j = 0; j < 2; j++) begin
            for (int i = 0; i < 8; i++) b[7 - i] = pat(k0 + 8 * j + i)[1];
            pop_check(b, "R1 single read samples io1");
        end
    endtask

    // quad instruction, 8-bit address, quad write of one byte
    task automatic t_short_addr();
        int gap;
        arm();
        wr(3'd1, 32'd0);
        wr(3'd3, 32'hC3);
        wr(3'd0, mkcfg(2, 2, 2, 0, 0, 0, 8'h38, 1));
        check(busy == 1'b0, "R6 address mode needs address write", busy, 0);
        wr(3'd2, 32'hFFFFFF5A);
        exp_bits(32'h38, 8, 2, 1);
        exp_bits(32'h5A, 8, 2, 1);
        exp_bits(32'hC3, 8, 2, 1);
        wait_idle(gap);
        cmp_edges("R3 R2 8-bit address quad write");
        check(rx_level == 4'd0, "R11 tx byte consumed", rx_level, 0);
    endtask

    task automatic t_instr_only();
        int gap;
        arm();
        wr(3'd0, mkcfg(1, 0, 0, 0, 0, 0, 8'h06, 1));
        exp_bits(32'h06, 8, 1, 1);
        wait_idle(gap);
        cmp_edges("R12 instruction only");
        check(gap == 2, "R7 cs release after instruction", gap, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_quad_read();
        t_flag_clear();
        t_write_stall();
        t_single_read();
        t_short_addr();
        t_instr_only();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule